// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is one programmable core performance counter. Every clock cycle it receives the number of times a monitored event happened in that cycle, together with the current privilege level, an in-transaction flag and a transaction-abort pulse. A set of qualification rules decides how much the cycle adds to a 48-bit counter. The rules are a threshold compare, inversion, rising-edge detection, user and kernel privilege filters, a transaction-only filter and exclusion of counts made in aborted transactions. A global enable turns all counting on or off.

A single write port holds the configuration, loads the counter and clears it. The counter value, a sticky overflow flag and a configuration-error flag are driven straight out as outputs.

Abort exclusion is handled by a small state machine with three states. `TX_IDLE` means no tracked transaction. `TX_OPEN` means a tracked transaction is running and counts go to a shadow accumulator. `TX_ABORTED` means the transaction was aborted and counts are thrown away until the in-transaction flag drops. The transitions are:
- Enter: `TX_IDLE` goes to `TX_OPEN` when the in-transaction flag is high and abort exclusion is on.
- Abort on entry: `TX_IDLE` goes to `TX_ABORTED` when an abort arrives in that same first cycle.
- Abort: `TX_OPEN` goes to `TX_ABORTED` on an abort.
- Commit: `TX_OPEN` goes to `TX_IDLE` when the in-transaction flag drops. The shadow value is added to the counter.
- Drain: `TX_ABORTED` goes to `TX_IDLE` when the in-transaction flag drops.

Top module: `qpc_top`

## Requirements
- R1: After reset, `count` is 0, `ovf` is 0 and `cfg_err` is 0. The configuration is all zeros, so nothing is counted.
- R2: With threshold 0 (and no inversion or edge detection), each counted cycle adds its full `ev_count`. With a nonzero threshold, a cycle qualifies when `ev_count >= threshold` and adds exactly 1.
- R3: With inversion set, a cycle adds 1 when it does not meet the qualifying condition. With threshold 0 the qualifying condition is `ev_count != 0`.
- R4: With edge detection set, 1 is added only in a cycle where the (possibly inverted) condition holds and did not hold in the previous cycle. The previous-cycle condition is tracked on every cycle, including gated ones, and resets to 0.
- R5: Edge detection with threshold 0 is an illegal setting. It raises `cfg_err`, and while `cfg_err` is high no increments are produced.
- R6: Privilege level 0 counts only when the kernel enable is set. Levels 1, 2 and 3 count only when the user enable is set.
- R7: With transaction-only set, cycles with `in_txn` low add nothing.
- R8: With abort exclusion set, increments made while `in_txn` is high are held in a shadow value. The shadow value is added to `count` in the cycle `in_txn` falls, together with that cycle's own increment. An abort pulse while `in_txn` is high drops the shadow value, and everything until `in_txn` falls is lost. Transitions are taken as listed in the state description above.
- R9: `count` wraps modulo 2^48. A carry out sets `ovf`, which stays set until a clear.
- R10: A write to address 1 loads `wr_data` into `count` and leaves `ovf` unchanged. A write to address 2 sets `count` and `ovf` to 0. In either case that cycle's increment is lost.
- R11: A write to address 0 stores the configuration, which takes effect from the next cycle. Its bits are: `wr_data[7:0]` threshold, [8] user enable, [9] kernel enable, [10] invert, [11] edge, [12] transaction-only, [13] abort exclusion, [14] global enable. With the global enable at 0, nothing is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_count | input | EVW (4) | Event occurrences in this cycle |
| priv_lvl | input | 2 | Current privilege level, 0 is kernel |
| in_txn | input | 1 | Executing inside a transactional region |
| txn_abort | input | 1 | The current transaction aborts this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 config, 1 load counter, 2 clear |
| wr_data | input | W (48) | Write data |
| count | output | W (48) | Counter value |
| ovf | output | 1 | Sticky overflow |
| cfg_err | output | 1 | Illegal configuration (edge detection with threshold 0) |

## Verification
The counting rules are tried with several input patterns:
- Raw counts under threshold 0, which separates adding the full count from adding one per cycle.
- Counts just below, at and above a nonzero threshold, which locates the compare boundary.
- Square-wave and constant event streams under edge detection, which separate level counting from transition counting.

Privilege levels 0 to 3 are swept under each privilege enable. Transactions that commit, abort in their first cycle, and abort midway with the flag held afterwards, each tell a different state path apart. A long seeded random run with occasional configuration writes mixes all these rules against a bench model.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
    localparam int THR_W = 8;

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_LOAD  = 2'd1;
    localparam logic [1:0] ADDR_CLEAR = 2'd2;

    typedef struct packed {
        logic             gen;
        logic             excl_abort;
        logic             txn_only;
        logic             edge_en;
        logic             invert;
        logic             kern_en;
        logic             user_en;
        logic [THR_W-1:0] thr;
    } qpc_cfg_t;

    localparam int CFG_W = $bits(qpc_cfg_t);

    typedef enum logic [1:0] {
        TX_IDLE    = 2'd0,
        TX_OPEN    = 2'd1,
        TX_ABORTED = 2'd2
    } qpc_txst_t;
endpackage

// File: rtl/qpc_qualify.sv
module qpc_qualify
    import qpc_pkg::*;
#(
    parameter int EVW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  qpc_cfg_t       cfg,
    input  logic [EVW-1:0] ev_count,
    input  logic [1:0]     priv_lvl,
    input  logic           in_txn,
    output logic [EVW-1:0] inc,
    output logic           cfg_err
);
    logic thr_zero, ge_thr, cond, pol, prev_pol, hit;
    logic priv_ok, txn_ok, gate;
    logic [EVW-1:0] amount;

    always_comb begin
        thr_zero = (cfg.thr == '0);
        ge_thr   = ({{THR_W{1'b0}}, ev_count} >= {{EVW{1'b0}}, cfg.thr});
        cond     = thr_zero ? (ev_count != '0) : ge_thr;
        pol      = cond ^ cfg.invert;
        hit      = cfg.edge_en ? (pol & ~prev_pol) : pol;
        if (thr_zero && !cfg.invert && !cfg.edge_en)
            amount = ev_count;
        else
            amount = {{(EVW-1){1'b0}}, hit};
        cfg_err  = cfg.edge_en & thr_zero;
        priv_ok  = (priv_lvl == 2'd0) ? cfg.kern_en : cfg.user_en;
        txn_ok   = ~cfg.txn_only | in_txn;
        gate     = cfg.gen & ~cfg_err & priv_ok & txn_ok;
        inc      = gate ? amount : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_pol <= 1'b0;
        else        prev_pol <= pol;
    end

    // R2: a nonzero threshold never adds more than one per cycle
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.thr != '0) |-> (inc <= 1));

    // R5: an illegal configuration produces no increments
    a_r5_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (inc == '0));
endmodule

// File: rtl/qpc_txn_fsm.sv
module qpc_txn_fsm
    import qpc_pkg::*;
#(
    parameter int W   = 48,
    parameter int EVW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           excl_abort,
    input  logic           in_txn,
    input  logic           txn_abort,
    input  logic [EVW-1:0] inc,
    output logic [W-1:0]   main_add,
    output qpc_txst_t      state
);
    qpc_txst_t    state_nxt;
    logic [W-1:0] shadow, shadow_nxt, inc_w;

    assign inc_w = {{(W-EVW){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            shadow <= '0;
        end else begin
            state  <= state_nxt;
            shadow <= shadow_nxt;
        end
    end

    always_comb begin
        state_nxt  = state;
        shadow_nxt = shadow;
        main_add   = '0;
        unique case (state)
            TX_IDLE: begin
                if (in_txn && excl_abort) begin
                    if (txn_abort) begin
                        state_nxt  = TX_ABORTED;
                        shadow_nxt = '0;
                    end else begin
                        state_nxt  = TX_OPEN;
                        shadow_nxt = inc_w;
                    end
                end else begin
                    main_add = inc_w;
                end
            end
            TX_OPEN: begin
                if (in_txn) begin
                    if (txn_abort) begin
                        state_nxt  = TX_ABORTED;
                        shadow_nxt = '0;
                    end else begin
                        shadow_nxt = shadow + inc_w;
                    end
                end else begin
                    main_add   = shadow + inc_w;
                    shadow_nxt = '0;
                    state_nxt  = TX_IDLE;
                end
            end
            TX_ABORTED: begin
                if (!in_txn) begin
                    main_add  = inc_w;
                    state_nxt = TX_IDLE;
                end
            end
            default: begin
                state_nxt  = TX_IDLE;
                shadow_nxt = '0;
            end
        endcase
    end

    // R8: nothing reaches the counter from inside a tracked transaction
    a_r8_open_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_OPEN && in_txn) |-> (main_add == '0));

    a_r8_aborted_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ABORTED && in_txn) |-> (main_add == '0));

    a_r8_abort_to_aborted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_OPEN && in_txn && txn_abort) |=> (state == TX_ABORTED));
endmodule

// File: rtl/qpc_main_cnt.sv
module qpc_main_cnt #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] add,
    input  logic         wr_load,
    input  logic         wr_clear,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         ovf
);
    logic [W:0] sum;

    assign sum = {1'b0, count} + {1'b0, add};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (wr_clear) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (wr_load) begin
            count <= load_val;
        end else begin
            count <= sum[W-1:0];
            if (sum[W]) ovf <= 1'b1;
        end
    end

    // R9: overflow is sticky until cleared
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_clear) |=> ovf);

    // R10: load and clear act in the next cycle
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !wr_clear) |=> (count == $past(load_val)));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clear |=> (count == '0 && !ovf));
endmodule

// File: rtl/qpc_top.sv
module qpc_top
    import qpc_pkg::*;
#(
    parameter int W   = 48,
    parameter int EVW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] ev_count,
    input  logic [1:0]     priv_lvl,
    input  logic           in_txn,
    input  logic           txn_abort,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [W-1:0]   count,
    output logic           ovf,
    output logic           cfg_err
);
    qpc_cfg_t       cfg;
    logic [EVW-1:0] inc;
    logic [W-1:0]   main_add;
    qpc_txst_t      txst;
    logic           wr_cfg, wr_load, wr_clear;

    assign wr_cfg   = wr_en && (wr_addr == ADDR_CFG);
    assign wr_load  = wr_en && (wr_addr == ADDR_LOAD);
    assign wr_clear = wr_en && (wr_addr == ADDR_CLEAR);

    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (wr_cfg) cfg <= qpc_cfg_t'(wr_data[CFG_W-1:0]);
    end

    qpc_qualify #(.EVW(EVW)) i_qualify (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .ev_count(ev_count),
        .priv_lvl(priv_lvl), .in_txn(in_txn), .inc(inc), .cfg_err(cfg_err)
    );

    qpc_txn_fsm #(.W(W), .EVW(EVW)) i_txn (
        .clk(clk), .rst_n(rst_n), .excl_abort(cfg.excl_abort), .in_txn(in_txn),
        .txn_abort(txn_abort), .inc(inc), .main_add(main_add), .state(txst)
    );

    qpc_main_cnt #(.W(W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .add(main_add), .wr_load(wr_load),
        .wr_clear(wr_clear), .load_val(wr_data), .count(count), .ovf(ovf)
    );

    // R11: global enable off keeps the counter still outside transactions
    a_r11_off_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.gen && txst == TX_IDLE && !in_txn && !wr_en) |=> $stable(count));

    // R5: an illegal setting holds the counter outside transactions
    a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && txst == TX_IDLE && !in_txn && !wr_en) |=> $stable(count));
endmodule

// File: tb/test_qpc_top.sv
`timescale 1ns/1ps
module test_qpc_top;
    localparam int W = 48;
    localparam int EVW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [EVW-1:0] ev_count = '0;
    logic [1:0] priv_lvl = '0, wr_addr = '0;
    logic in_txn = 1'b0, txn_abort = 1'b0, wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count;
    logic ovf, cfg_err;

    int n_cmp = 0, n_bad = 0;

    logic [14:0] m_cfg;
    logic m_prev;
    int m_state;
    logic [W:0] m_shadow, m_cnt;
    logic m_ovf;

    always #5 clk = ~clk;

    qpc_top #(.W(W), .EVW(EVW)) i_qpc_top (
        .clk(clk), .rst_n(rst_n), .ev_count(ev_count), .priv_lvl(priv_lvl),
        .in_txn(in_txn), .txn_abort(txn_abort), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .ovf(ovf), .cfg_err(cfg_err)
    );

    function automatic logic [W-1:0] cfgw(input bit gen, exa, txo, edg, inv, kern, user,
                                          input int thr);
        return {33'd0, gen, exa, txo, edg, inv, kern, user, thr[7:0]};
    endfunction

    function automatic bit model_err();
        return m_cfg[11] && (m_cfg[7:0] == 8'd0);
    endfunction

    task automatic check(input string tag);
        n_cmp++;
        if (count !== m_cnt[W-1:0] || ovf !== m_ovf || cfg_err !== model_err()) begin
            n_bad++;
            $display("FAIL %s: count=%0d ovf=%0b err=%0b expected count=%0d ovf=%0b err=%0b",
                     tag, count, ovf, cfg_err, m_cnt[W-1:0], m_ovf, model_err());
        end
    endtask

    task automatic cyc(input int ev, input int pl, input bit tx, input bit ab,
                       input bit we, input int addr, input logic [W-1:0] data,
                       input string tag);
        int thr, amt, inc;
        bit cond, pol, hit, gate;
        logic [W:0] add, sum;
        ev_count = ev[EVW-1:0]; priv_lvl = pl[1:0]; in_txn = tx; txn_abort = ab;
        wr_en = we; wr_addr = addr[1:0]; wr_data = data;
        thr  = m_cfg[7:0];
        cond = (thr == 0) ? (ev != 0) : (ev >= thr);
        pol  = cond ^ m_cfg[10];
        hit  = m_cfg[11] ? (pol && !m_prev) : pol;
        amt  = (thr == 0 && !m_cfg[10] && !m_cfg[11]) ? ev : int'(hit);
        gate = m_cfg[14] && !model_err() && ((pl == 0) ? m_cfg[9] : m_cfg[8])
               && (!m_cfg[12] || tx);
        inc  = gate ? amt : 0;
        add  = '0;
        case (m_state)
            0: if (tx && m_cfg[13]) begin
                   m_shadow = ab ? '0 : (W+1)'(inc);
                   m_state  = ab ? 2 : 1;
               end else add = (W+1)'(inc);
            1: if (tx) begin
                   if (ab) begin m_shadow = '0; m_state = 2; end
                   else m_shadow = m_shadow + (W+1)'(inc);
               end else begin
                   add = m_shadow + (W+1)'(inc); m_shadow = '0; m_state = 0;
               end
            default: if (!tx) begin add = (W+1)'(inc); m_state = 0; end
        endcase
        m_prev = pol;
        @(posedge clk);
        if (we && addr == 2) begin m_cnt = '0; m_ovf = 1'b0; end
        else if (we && addr == 1) m_cnt = {1'b0, data};
        else begin
            sum = {1'b0, m_cnt[W-1:0]} + {1'b0, add[W-1:0]};
            if (sum[W]) m_ovf = 1'b1;
            m_cnt = {1'b0, sum[W-1:0]};
        end
        if (we && addr == 0) m_cfg = data[14:0];
        #1;
        check(tag);
    endtask

    task automatic ev_cyc(input int ev, input string tag);
        cyc(ev, 3, 1'b0, 1'b0, 1'b0, 0, '0, tag);
    endtask

    task automatic setcfg(input logic [W-1:0] c, input string tag);
        cyc(0, 3, 1'b0, 1'b0, 1'b1, 0, c, tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_cfg = '0; m_prev = 0; m_state = 0; m_shadow = '0; m_cnt = '0; m_ovf = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset state");
        ev_cyc(5, "R1 zero config counts nothing");

        // R11: global enable off, then on; effect from next cycle
        setcfg(cfgw(0,0,0,0,0,1,1,0), "R11");
        ev_cyc(7, "R11 gen off");
        cyc(5, 3, 0, 0, 1'b1, 0, cfgw(1,0,0,0,0,1,1,0), "R11 write cycle uses old cfg");
        ev_cyc(5, "R11 takes effect next cycle");

        // R2: raw count and threshold
        ev_cyc(15, "R2 raw 15");
        ev_cyc(0, "R2 raw 0");
        setcfg(cfgw(1,0,0,0,0,1,1,3), "R2");
        ev_cyc(2, "R2 below threshold");
        ev_cyc(3, "R2 at threshold");
        ev_cyc(9, "R2 above threshold adds 1");

        // R3: inversion
        setcfg(cfgw(1,0,0,0,1,1,1,3), "R3");
        ev_cyc(2, "R3 inverted below");
        ev_cyc(4, "R3 inverted above");
        setcfg(cfgw(1,0,0,0,1,1,1,0), "R3");
        ev_cyc(0, "R3 inverted thr0 zero");
        ev_cyc(6, "R3 inverted thr0 nonzero");

        // R4: edge detection
        setcfg(cfgw(1,0,0,1,0,1,1,1), "R4");
        for (int i = 0; i < 8; i++) ev_cyc((i % 2) ? 2 : 0, "R4 square wave");
        for (int i = 0; i < 4; i++) ev_cyc(3, "R4 steady level");

        // R5: illegal edge with threshold 0
        setcfg(cfgw(1,0,0,1,0,1,1,0), "R5");
        for (int i = 0; i < 4; i++) ev_cyc(i * 3, "R5 error suppresses");

        // R6: privilege
        setcfg(cfgw(1,0,0,0,0,0,1,0), "R6");
        for (int p = 0; p < 4; p++) cyc(4, p, 0, 0, 0, 0, '0, "R6 user only");
        setcfg(cfgw(1,0,0,0,0,1,0,0), "R6");
        for (int p = 0; p < 4; p++) cyc(4, p, 0, 0, 0, 0, '0, "R6 kernel only");

        // R7: transaction only
        setcfg(cfgw(1,0,1,0,0,1,1,0), "R7");
        cyc(3, 1, 0, 0, 0, 0, '0, "R7 outside");
        cyc(3, 1, 1, 0, 0, 0, '0, "R7 inside");

        // R8: abort exclusion
        setcfg(cfgw(1,1,0,0,0,1,1,0), "R8");
        cyc(2, 1, 1, 0, 0, 0, '0, "R8 open");
        cyc(3, 1, 1, 0, 0, 0, '0, "R8 held");
        cyc(4, 1, 0, 0, 0, 0, '0, "R8 commit");
        cyc(5, 1, 1, 0, 0, 0, '0, "R8 open2");
        cyc(6, 1, 1, 1, 0, 0, '0, "R8 abort midway");
        cyc(7, 1, 1, 0, 0, 0, '0, "R8 aborted drains");
        cyc(1, 1, 0, 0, 0, 0, '0, "R8 leave aborted");
        cyc(8, 1, 1, 1, 0, 0, '0, "R8 abort on entry");
        cyc(2, 1, 0, 0, 0, 0, '0, "R8 after entry abort");

        // R9 / R10: wrap, sticky, load, clear
        setcfg(cfgw(1,0,0,0,0,1,1,0), "R9");
        cyc(9, 1, 0, 0, 1'b1, 1, {W{1'b1}} - 48'd3, "R10 load ignores event");
        ev_cyc(2, "R9 near max");
        ev_cyc(5, "R9 wraps sets ovf");
        ev_cyc(1, "R9 ovf sticky");
        cyc(1, 1, 0, 0, 1'b1, 1, 48'd100, "R10 load keeps ovf");
        cyc(4, 1, 0, 0, 1'b1, 2, '0, "R10 clear");

        // random mix
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            bit we; int addr; logic [W-1:0] d;
            we = ($urandom % 40) == 0;
            addr = $urandom % 3;
            d = (addr == 0) ? cfgw(($urandom % 8) != 0, $urandom % 2, $urandom % 2,
                                   $urandom % 2, $urandom % 2, $urandom % 2,
                                   $urandom % 2, $urandom % 6)
                            : {$urandom, $urandom} & ((addr == 1) ? {W{1'b1}} : '0);
            cyc($urandom % 16, $urandom % 4, ($urandom % 3) != 0,
                ($urandom % 16) == 0, we, addr, d, "R2 R8 random mix");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule